// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters that share one input clock. Each channel has its own power-of-two prescaler, a stop/restart control, a choice between a free-running mode that wraps at the top of the counter range and an interval mode that returns to zero at a programmable limit, and a two-bit interrupt status word. Reading the status word clears it. Each channel drives one interrupt line, which is active while any pending status bit has its enable bit set.

Software reaches the registers over a simple register bus. A write takes effect on the clock edge where `wr_en` is sampled high. A read returns its data on `rd_data` one cycle after `rd_en` is sampled. Every register kind occupies a group of three consecutive 32-bit words, one per channel.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel reads: clock setup 0, counter control 0x21, count 0, limit 0, status 0 and enable 0. All interrupt lines are low.
- R2: Channel n (0 to 2) has these byte addresses: clock setup 0x00+4n, counter control 0x0C+4n, count 0x18+4n (read-only), limit 0x24+4n, status 0x54+4n (read-only), enable 0x60+4n. Any other address, including a misaligned one, reads as 0.
- R3: With counter-control bit 1 clear, a running counter advances by one on each prescaled tick. It wraps from 0xFFFF to 0, and that wrap sets status bit 1.
- R4: Clock setup bit 0 enables the prescaler, and bits 4:1 hold an exponent N. With the prescaler enabled, one tick occurs every 2^(N+1) clocks. With it disabled, one tick occurs every clock, whatever N holds.
- R5: Counter-control bit 0 set stops the counter, which keeps its value. Clearing the bit resumes counting from that value.
- R6: A write of counter control with bit 4 set clears the count and the prescaler phase to 0, so counting restarts from zero. Bit 4 always reads back as 0.
- R7: With counter-control bit 1 set, the counter counts from 0 up to the limit. On the next tick it returns to 0 and sets status bit 0. With a limit of 0, the count stays at 0 and bit 0 is set on every tick.
- R8: A read of a status word returns the pending bits and clears them in the same access. An event that arrives on that same clock edge stays pending.
- R9: A channel's interrupt line is high when any status bit is set and the enable bit in the same position is set.
- R10: Counter-control bit 5 is stored and read back and has no other effect. Writes to the count and status words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock shared by all channels |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, which also clears a status word |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 3 | One interrupt line per channel |

## Verification
The assertions check the counter behaviour on every cycle. They cover the single step, wrap and return to zero, holding while no tick arrives, clearing on a restart, ticks only while running, and the rule that a new event outlives a read-clear in the same cycle. The bench scenarios are the only place that shows the things no single-cycle property can see. These are the exact tick rate for each prescaler exponent, the count and flag left after a random number of cycles in interval mode, the full 65536-tick wrap, the register map with its unused holes, and the masking of the interrupt lines.

// File: rtl/tmr_pkg.sv
// Shared constants for the three-channel timer: register map, control bit
// positions and status flag positions. Assumes a byte-addressed 32-bit bus.
package tmr_pkg;
    localparam int NUM_CH = 3;
    localparam int CNT_W  = 16;
    localparam int EXP_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int STRIDE = 4;

    localparam logic [7:0] BASE_CLK = 8'h00;
    localparam logic [7:0] BASE_CTL = 8'h0C;
    localparam logic [7:0] BASE_VAL = 8'h18;
    localparam logic [7:0] BASE_LIM = 8'h24;
    localparam logic [7:0] BASE_STS = 8'h54;
    localparam logic [7:0] BASE_ENA = 8'h60;

    localparam int CTL_STOP    = 0;
    localparam int CTL_INTV    = 1;
    localparam int CTL_RESTART = 4;
    localparam int CTL_AUX     = 5;

    localparam int FLG_W    = 2;
    localparam int FLG_INTV = 0;
    localparam int FLG_OVF  = 1;
endpackage

// File: rtl/tmr_prescaler.sv
// Tick generator for one channel. It emits a single-cycle tick every
// 2^(exp+1) clocks while enabled, or every clock when bypassed. It assumes
// restart and run come from registered control, and produces no tick while
// stopped.
module tmr_prescaler #(
    parameter int EXP_W = 4,
    localparam int PS_W = 1 << EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             pre_en,
    input  logic [EXP_W-1:0] exp_n,
    output logic             tick
);
    logic [PS_W-1:0]  phase_q;
    logic [PS_W-1:0]  mask;
    logic [EXP_W:0]   shift;

    // Builds the low-bit mask that marks the last clock of a prescaled period.
    always_comb begin
        shift = {1'b0, exp_n} + 1'b1;
        mask  = ~({PS_W{1'b1}} << shift);
    end

    assign tick = run && (!pre_en || ((phase_q & mask) == mask));

    // Advances the phase counter while running and clears it on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (restart)  phase_q <= '0;
        else if (run)      phase_q <= phase_q + 1'b1;
    end

    a_r4_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    a_r6_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));
endmodule

// File: rtl/tmr_counter.sv
// Count register for one channel. In interval mode it counts from 0 up to
// the limit and then returns to zero. In free mode it wraps at all-ones.
// It reports one event pulse per completed period. It assumes that tick is
// already qualified by run.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             intv_mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             evt_intv,
    output logic             evt_ovf
);
    logic live;

    assign live     = tick && !restart;
    assign evt_intv = live && intv_mode && (count >= limit);
    assign evt_ovf  = live && !intv_mode && (&count);

    // Clears on restart, returns to zero on a period end, otherwise steps.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (restart)                count <= '0;
        else if (evt_intv || evt_ovf)    count <= '0;
        else if (tick)                   count <= count + 1'b1;
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !intv_mode) |=> (count == CNT_W'($past(count) + 1'b1)));
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
    a_r7_limit_return: assert property (@(posedge clk) disable iff (!rst_n)
        (live && intv_mode && (count >= limit)) |=> (count == '0));
endmodule

// File: rtl/tmr_irq_status.sv
// Pending-event flags for one channel, with clear on read and a per-flag
// enable mask that forms the interrupt line. An event on the edge of a
// read-clear wins.
module tmr_irq_status #(
    parameter int FLG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLG_W-1:0] evt,
    input  logic             rd_clr,
    input  logic [FLG_W-1:0] enable,
    output logic [FLG_W-1:0] status,
    output logic             irq
);
    // Clears the flags on a read, then merges in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (rd_clr ? '0 : status) | evt;
    end

    assign irq = |(status & enable);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (evt == '0)) |=> (status == '0));
    a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);
endmodule

// File: rtl/tri_interval_timer.sv
// Top of the three-channel timer. It decodes the register bus, holds the
// per-channel configuration and instantiates the prescaler, counter and
// status logic for each channel. Writes act on the edge where wr_en is
// sampled. Read data is registered one cycle after rd_en.
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int N_CH    = NUM_CH,
    parameter int C_W     = CNT_W,
    parameter int E_W     = EXP_W,
    parameter int A_W     = ADDR_W,
    parameter int D_W     = DATA_W,
    localparam int CFG_W  = E_W + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] bus_addr,
    input  logic           wr_en,
    input  logic [D_W-1:0] wr_data,
    input  logic           rd_en,
    output logic [D_W-1:0] rd_data,
    output logic [N_CH-1:0] irq
);
    logic [D_W-1:0] rd_word [N_CH];
    logic [D_W-1:0] rd_mux;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam logic [A_W-1:0] OFS = A_W'(STRIDE * c);

        logic hit_clk, hit_ctl, hit_val, hit_lim, hit_sts, hit_ena;
        logic [CFG_W-1:0] clk_cfg_q;
        logic             stop_q, intv_q, aux_q;
        logic [C_W-1:0]   limit_q;
        logic [FLG_W-1:0] ena_q;
        logic             restart, run, tick;
        logic [C_W-1:0]   count;
        logic             evt_intv, evt_ovf;
        logic [FLG_W-1:0] status;
        logic [FLG_W-1:0] evt;

        assign hit_clk = (bus_addr == A_W'(BASE_CLK) + OFS);
        assign hit_ctl = (bus_addr == A_W'(BASE_CTL) + OFS);
        assign hit_val = (bus_addr == A_W'(BASE_VAL) + OFS);
        assign hit_lim = (bus_addr == A_W'(BASE_LIM) + OFS);
        assign hit_sts = (bus_addr == A_W'(BASE_STS) + OFS);
        assign hit_ena = (bus_addr == A_W'(BASE_ENA) + OFS);

        assign restart = wr_en && hit_ctl && wr_data[CTL_RESTART];
        assign run     = !stop_q;

        // Stores the writable configuration words of this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_cfg_q <= '0;
                stop_q    <= 1'b1;
                intv_q    <= 1'b0;
                aux_q     <= 1'b1;
                limit_q   <= '0;
                ena_q     <= '0;
            end else if (wr_en) begin
                if (hit_clk) clk_cfg_q <= wr_data[CFG_W-1:0];
                if (hit_ctl) begin
                    stop_q <= wr_data[CTL_STOP];
                    intv_q <= wr_data[CTL_INTV];
                    aux_q  <= wr_data[CTL_AUX];
                end
                if (hit_lim) limit_q <= wr_data[C_W-1:0];
                if (hit_ena) ena_q   <= wr_data[FLG_W-1:0];
            end
        end

        tmr_prescaler #(.EXP_W(E_W)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .restart (restart),
            .pre_en  (clk_cfg_q[0]),
            .exp_n   (clk_cfg_q[CFG_W-1:1]),
            .tick    (tick)
        );

        tmr_counter #(.CNT_W(C_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .restart   (restart),
            .intv_mode (intv_q),
            .limit     (limit_q),
            .count     (count),
            .evt_intv  (evt_intv),
            .evt_ovf   (evt_ovf)
        );

        always_comb begin
            evt           = '0;
            evt[FLG_INTV] = evt_intv;
            evt[FLG_OVF]  = evt_ovf;
        end

        tmr_irq_status #(.FLG_W(FLG_W)) u_sts (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt),
            .rd_clr (rd_en && hit_sts),
            .enable (ena_q),
            .status (status),
            .irq    (irq[c])
        );

        // Selects the word this channel contributes to a read.
        always_comb begin
            rd_word[c] = '0;
            if (hit_clk) rd_word[c][CFG_W-1:0] = clk_cfg_q;
            if (hit_ctl) begin
                rd_word[c][CTL_STOP] = stop_q;
                rd_word[c][CTL_INTV] = intv_q;
                rd_word[c][CTL_AUX]  = aux_q;
            end
            if (hit_val) rd_word[c][C_W-1:0]   = count;
            if (hit_lim) rd_word[c][C_W-1:0]   = limit_q;
            if (hit_sts) rd_word[c][FLG_W-1:0] = status;
            if (hit_ena) rd_word[c][FLG_W-1:0] = ena_q;
        end

        a_r1_stopped_after_reset: assert property (@(posedge clk)
            $rose(rst_n) |-> (stop_q && (count == '0)));
    end

    // Merges the channel words; at most one channel matches an address.
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < N_CH; c++) rd_mux = rd_mux | rd_word[c];
    end

    // Registers the read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end
endmodule

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
    localparam int CLK_ST = 8'h00, CTL = 8'h0C, VAL = 8'h18, LIM = 8'h24, STS = 8'h54, ENA = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [2:0]  irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tri_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [7:0] ra(int base, int ch);
        return 8'(base + 4 * ch);
    endfunction

    function automatic int tick_period(int pen, int n);
        return pen != 0 ? (1 << (n + 1)) : 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", {29'd0, irq}, 32'd0);

        for (int c = 0; c < 3; c++) begin
            rd(ra(CLK_ST, c), d); chk("R1 clock setup", d, 32'h0);
            rd(ra(CTL, c), d);    chk("R1 counter control", d, 32'h21);
            rd(ra(VAL, c), d);    chk("R1 count", d, 32'h0);
            rd(ra(LIM, c), d);    chk("R1 limit", d, 32'h0);
            rd(ra(STS, c), d);    chk("R1 status", d, 32'h0);
            rd(ra(ENA, c), d);    chk("R1 enable", d, 32'h0);
        end

        // R2: the register map and its holes.
        wr(ra(LIM, 2), 32'h0000_BEEF);
        rd(ra(LIM, 2), d); chk("R2 limit ch2", d, 32'hBEEF);
        rd(ra(LIM, 1), d); chk("R2 limit ch1 untouched", d, 32'h0);
        rd(8'h40, d);      chk("R2 unused word", d, 32'h0);
        rd(8'h30, d);      chk("R2 unused word", d, 32'h0);
        rd(8'h0D, d);      chk("R2 misaligned", d, 32'h0);

        // R6 and R10: control read-back.
        wr(ra(CTL, 1), 32'h0000_0033);
        rd(ra(CTL, 1), d); chk("R6 restart bit reads 0, R10 aux kept", d, 32'h23);
        wr(ra(CTL, 1), 32'h0000_0001);
        rd(ra(CTL, 1), d); chk("R10 aux cleared", d, 32'h01);
        wr(ra(VAL, 1), 32'h0000_1234);
        rd(ra(VAL, 1), d); chk("R10 count write ignored", d, 32'h0);

        // R5: stop holds, clearing resumes from the held value.
        wr(ra(CTL, 0), 32'h10);
        repeat (9) @(negedge clk);
        wr(ra(CTL, 0), 32'h01);
        rd(ra(VAL, 0), d); chk("R5 count after 10", d, 32'd10);
        repeat (20) @(negedge clk);
        rd(ra(VAL, 0), d); chk("R5 held while stopped", d, 32'd10);
        wr(ra(CTL, 0), 32'h00);
        repeat (4) @(negedge clk);
        wr(ra(CTL, 0), 32'h01);
        rd(ra(VAL, 0), d); chk("R5 resumed", d, 32'd15);

        // R6: restart while stopped.
        wr(ra(CTL, 0), 32'h11);
        rd(ra(VAL, 0), d); chk("R6 restart clears", d, 32'd0);

        // R4: prescaled and bypassed rates.
        wr(ra(CLK_ST, 2), (2 << 1) | 1);
        wr(ra(CTL, 2), 32'h10);
        repeat (39) @(negedge clk);
        wr(ra(CTL, 2), 32'h01);
        rd(ra(VAL, 2), d); chk("R4 divide by 8", d, 32'd5);
        wr(ra(CLK_ST, 2), (5 << 1));
        wr(ra(CTL, 2), 32'h10);
        repeat (6) @(negedge clk);
        wr(ra(CTL, 2), 32'h01);
        rd(ra(VAL, 2), d); chk("R4 prescaler bypassed", d, 32'd7);

        // R7 and R8: limit 0 raises an event every tick, which outlives a read-clear.
        wr(ra(CLK_ST, 2), 32'h0);
        wr(ra(LIM, 2), 32'h0);
        wr(ra(ENA, 2), 32'h1);
        wr(ra(CTL, 2), 32'h12);
        repeat (5) @(negedge clk);
        rd(ra(VAL, 2), d);  chk("R7 limit 0 stays at 0", d, 32'd0);
        rd(ra(STS, 2), d);  chk("R7 limit 0 flags", d, 32'h1);
        chk("R8 event wins over clear", {31'd0, irq[2]}, 32'd1);
        wr(ra(CTL, 2), 32'h03);
        rd(ra(STS, 2), d);  chk("R8 pending at stop", d, 32'h1);
        chk("R8 cleared so irq low", {31'd0, irq[2]}, 32'd0);

        // R3, R8, R9, R10: a full free-running wrap.
        wr(ra(CLK_ST, 1), 32'h0);
        wr(ra(ENA, 1), 32'h3);
        wr(ra(CTL, 1), 32'h10);
        repeat (65539) @(negedge clk);
        wr(ra(CTL, 1), 32'h01);
        rd(ra(VAL, 1), d); chk("R3 count after wrap", d, 32'd4);
        chk("R9 irq on overflow", {31'd0, irq[1]}, 32'd1);
        wr(ra(ENA, 1), 32'h1);
        chk("R9 overflow masked by bit 1", {31'd0, irq[1]}, 32'd0);
        wr(ra(STS, 1), 32'h0);
        rd(ra(STS, 1), d); chk("R10 status write ignored, R3 overflow flag", d, 32'h2);
        rd(ra(STS, 1), d); chk("R8 read clears", d, 32'h0);

        // Random interval-mode trials: R4, R6, R7, R9.
        for (int t = 0; t < 40; t++) begin
            int ch, n, pen, lim, m, ie, ticks, periods;
            ch  = $urandom_range(0, 2);
            n   = $urandom_range(0, 3);
            pen = $urandom_range(0, 1);
            lim = $urandom_range(0, 20);
            m   = $urandom_range(1, 300);
            ie  = $urandom_range(0, 1);
            ticks   = m / tick_period(pen, n);
            periods = ticks / (lim + 1);
            wr(ra(CLK_ST, ch), 32'((n << 1) | pen));
            wr(ra(LIM, ch), 32'(lim));
            wr(ra(ENA, ch), 32'(ie));
            rd(ra(STS, ch), d);
            wr(ra(CTL, ch), 32'h12);
            repeat (m - 1) @(negedge clk);
            wr(ra(CTL, ch), 32'h03);
            rd(ra(VAL, ch), d);
            chk("R7 interval count (R4 rate, R6 restart)", d, 32'(ticks % (lim + 1)));
            chk("R9 irq follows enable", {31'd0, irq[ch]},
                32'((ie != 0 && periods > 0) ? 1 : 0));
            rd(ra(STS, ch), d);
            chk("R7 interval flag", d, 32'(periods > 0 ? 1 : 0));
        end

        report();
    end
endmodule